// File: doc/BRIEF.md
# Two-Pattern Scan Chain with Hold Stage

This block is a scan chain for two-pattern delay testing. Each scan cell feeds the logic under test through its own hold stage, which means the chain can keep one test vector applied to the logic while a second vector is shifted in behind it. The logic only sees the second vector when the hold stages are updated. That update is the launch event. One clock later the response of the logic is captured back into the scan cells and then shifted out serially.

The block runs in two ways. When the built-in sequencer is idle, the external shift, update and capture enables drive the chain directly. A `start` pulse hands control to the sequencer, which steps through a fixed order: load the first vector, transfer it, load the second vector, launch, capture, unload, and done. While the sequencer is busy it ignores the external enables. It reports its phase as a 3-bit code.

Top module: `esc_chain`

## Requirements
- R1: After reset, `ppi`, the scan cells and `scan_out` are all zero, `seq_state` is 0 (idle) and `done` is low.
- R2: When idle with `scan_en` high, every clock shifts the chain one place toward the last cell. `scan_in` enters cell 0, and `scan_out` always shows the last cell (index CHAIN_LEN-1).
- R3: When idle, a clock with `hold_upd` high copies the scan cells into `ppi`, using the cell values from before that edge. Otherwise `ppi` holds its value.
- R4: When idle with `cap_en` high and `scan_en` low, a clock loads `func_d` into the scan cells. If `scan_en` and `cap_en` are both high, the chain shifts.
- R5: After `start`, the sequencer steps through phase codes 1 (load first, CHAIN_LEN cycles), 2 (transfer, 1 cycle), 3 (load second, CHAIN_LEN cycles), 4 (launch, 1), 5 (capture, 1), 6 (unload, CHAIN_LEN), 7 (done, 1) and then 0. During the loads, `scan_in` bits enter one per cycle, and the last cell's bit goes in first.
- R6: Throughout phase 3, `ppi` holds the first vector. While the sequencer is busy, `scan_en`, `hold_upd` and `cap_en` have no effect.
- R7: The clock edge that ends phase 4 places the second vector on `ppi`.
- R8: The edge that ends phase 5 comes exactly one clock after launch. It loads into the scan cells the `func_d` value produced by the second vector.
- R9: During the CHAIN_LEN cycles of phase 6, `scan_out` presents the captured word, last cell first.
- R10: `done` is high for exactly the one cycle of phase 7. The block then returns to idle, and the external enables work again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequenced two-pattern test (idle only) |
| scan_in | input | 1 | Serial scan data into cell 0 |
| scan_en | input | 1 | Manual shift enable |
| hold_upd | input | 1 | Manual hold-stage update |
| cap_en | input | 1 | Manual capture of `func_d` |
| func_d | input | CHAIN_LEN | Next-state response from the logic under test |
| ppi | output | CHAIN_LEN | Held vector applied to the logic under test |
| scan_out | output | 1 | Serial scan data from the last cell |
| seq_state | output | 3 | Sequencer phase code |
| done | output | 1 | One-cycle end-of-test pulse |

## Verification
A corrupted scan cell shows up on `scan_out` as soon as shifting carries that cell to the end of the chain, at most CHAIN_LEN cycles later. A hold stage that updates at the wrong moment changes `ppi` within the same cycle. It is caught during phase 3, when `ppi` must not move, or at launch, when it must equal the second vector. A sequencer that skips or repeats a phase shows a wrong `seq_state` code on the next cycle. It also shifts the captured word out of position, so the unloaded response no longer matches what the logic model computes from the second vector.

// File: rtl/esc_pkg.sv
package esc_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_LOAD_A = 3'd1,
      PH_XFER   = 3'd2,
      PH_LOAD_B = 3'd3,
      PH_LAUNCH = 3'd4,
      PH_CAPT   = 3'd5,
      PH_UNLOAD = 3'd6,
      PH_DONE   = 3'd7
   } esc_phase_t;
endpackage

// File: rtl/esc_cell.sv
// One scan cell plus its hold stage. The hold stage is edge-triggered and
// enabled, so the held value changes only on an update edge.
module esc_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic shift,
   input  logic capture,
   input  logic update,
   input  logic si,
   input  logic d,
   output logic q,
   output logic h
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (shift) begin
         q <= si;
      end else if (capture) begin
         q <= d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h <= 1'b0;
      end else if (update) begin
         h <= q;
      end
   end
endmodule

// File: rtl/esc_sequencer.sv
module esc_sequencer
   import esc_pkg::*;
#(
   parameter int CHAIN_LEN = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   output esc_phase_t phase,
   output logic       seq_shift,
   output logic       seq_update,
   output logic       seq_capture,
   output logic       busy,
   output logic       done
);
   localparam int CW = $clog2(CHAIN_LEN + 1);
   localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN - 1);

   logic [CW-1:0] cnt;
   logic          last;

   assign last = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               cnt <= '0;
               if (start) phase <= PH_LOAD_A;
            end
            PH_LOAD_A, PH_LOAD_B, PH_UNLOAD: begin
               if (last) begin
                  cnt   <= '0;
                  phase <= esc_phase_t'(phase + 3'd1);
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_DONE: phase <= PH_IDLE;
            default: phase <= esc_phase_t'(phase + 3'd1);
         endcase
      end
   end

   always_comb begin
      seq_shift   = (phase == PH_LOAD_A) || (phase == PH_LOAD_B) || (phase == PH_UNLOAD);
      seq_update  = (phase == PH_XFER) || (phase == PH_LAUNCH);
      seq_capture = (phase == PH_CAPT);
      busy        = (phase != PH_IDLE);
      done        = (phase == PH_DONE);
   end
endmodule

// File: rtl/esc_chain.sv
module esc_chain
   import esc_pkg::*;
#(
   parameter int CHAIN_LEN = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 scan_in,
   input  logic                 scan_en,
   input  logic                 hold_upd,
   input  logic                 cap_en,
   input  logic [CHAIN_LEN-1:0] func_d,
   output logic [CHAIN_LEN-1:0] ppi,
   output logic                 scan_out,
   output logic [2:0]           seq_state,
   output logic                 done
);
   generate
      if (CHAIN_LEN < 2) begin : g_bad_len
         $error("esc_chain: CHAIN_LEN must be at least 2");
      end
   endgenerate

   esc_phase_t           phase;
   logic                 seq_shift, seq_update, seq_capture, busy;
   logic                 shift_en, upd_en, cap_sel;
   logic [CHAIN_LEN-1:0] chain_q;

   esc_sequencer #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .phase       (phase),
      .seq_shift   (seq_shift),
      .seq_update  (seq_update),
      .seq_capture (seq_capture),
      .busy        (busy),
      .done        (done)
   );

   // While the sequencer is busy, it alone controls the chain.
   always_comb begin
      if (busy) begin
         shift_en = seq_shift;
         upd_en   = seq_update;
         cap_sel  = seq_capture;
      end else begin
         shift_en = scan_en;
         upd_en   = hold_upd;
         cap_sel  = cap_en & ~scan_en;
      end
   end

   generate
      for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
         logic si_w;
         if (i == 0) begin : g_head
            assign si_w = scan_in;
         end else begin : g_body
            assign si_w = chain_q[i-1];
         end
         esc_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .shift   (shift_en),
            .capture (cap_sel),
            .update  (upd_en),
            .si      (si_w),
            .d       (func_d[i]),
            .q       (chain_q[i]),
            .h       (ppi[i])
         );
      end
   endgenerate

   assign scan_out  = chain_q[CHAIN_LEN-1];
   assign seq_state = phase;
endmodule

// File: rtl/esc_chain_chk.sv
module esc_chain_chk #(
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [2:0]   seq_state,
   input logic [N-1:0] ppi,
   input logic [N-1:0] chain,
   input logic [N-1:0] func_d,
   input logic         done
);
   p_xfer_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      seq_state == 3'd2 |=> seq_state == 3'd3);

   p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      seq_state == 3'd3 |=> $stable(ppi));

   p_launch_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seq_state == 3'd4 |=> ppi == $past(chain));

   p_launch_then_capt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_state == 3'd4 |=> seq_state == 3'd5);

   p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_state == 3'd5 |=> chain == $past(func_d));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && seq_state == 3'd0));
endmodule

bind esc_chain esc_chain_chk #(.N(CHAIN_LEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .seq_state (seq_state),
   .ppi       (ppi),
   .chain     (chain_q),
   .func_d    (func_d),
   .done      (done)
);

// File: tb/esc_chain_tb.sv
module esc_chain_tb;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0, scan_in = 1'b0, scan_en = 1'b0, hold_upd = 1'b0, cap_en = 1'b0;
   logic [N-1:0] func_d, ppi;
   logic         scan_out, done;
   logic [2:0]   seq_state;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   function automatic logic [N-1:0] logic_model(input logic [N-1:0] v);
      return {v[N-2:0], v[N-1]} ^ 8'hA5;
   endfunction

   assign func_d = logic_model(ppi);

   esc_chain #(.CHAIN_LEN(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .scan_in(scan_in),
      .scan_en(scan_en), .hold_upd(hold_upd), .cap_en(cap_en),
      .func_d(func_d), .ppi(ppi), .scan_out(scan_out),
      .seq_state(seq_state), .done(done)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // model of the chain in idle mode
   logic [N-1:0] m_q = '0, m_h = '0;

   task automatic manual_cycle(input bit se, input bit up, input bit ce, input bit si);
      logic [N-1:0] oq;
      scan_en = se; hold_upd = up; cap_en = ce; scan_in = si;
      oq = m_q;
      @(negedge clk);
      if (se)      m_q = {oq[N-2:0], si};
      else if (ce) m_q = logic_model(m_h);
      if (up)      m_h = oq;
      chk(scan_out == m_q[N-1], (!se && ce) ? "R4 capture" : "R2 shift", 32'(scan_out), 32'(m_q[N-1]));
      chk(ppi == m_h, "R3 hold", 32'(ppi), 32'(m_h));
   endtask

   task automatic run_seq(input logic [N-1:0] v1, input logic [N-1:0] v2, input bit poke);
      logic [N-1:0] cap;
      scan_en = 0; hold_upd = 0; cap_en = 0;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      chk(seq_state == 3'd1, "R5 phase load1", 32'(seq_state), 1);
      for (int k = 0; k < N; k++) begin
         scan_in = v1[N-1-k];
         @(negedge clk);
      end
      chk(seq_state == 3'd2, "R5 phase xfer", 32'(seq_state), 2);
      @(negedge clk);
      chk(seq_state == 3'd3, "R5 phase load2", 32'(seq_state), 3);
      chk(ppi == v1, "R6 first vector held", 32'(ppi), 32'(v1));
      for (int k = 0; k < N; k++) begin
         scan_in = v2[N-1-k];
         if (poke) begin hold_upd = 1; cap_en = 1; scan_en = 32'($urandom) & 1; end
         chk(ppi == v1, "R6 ppi steady in load2", 32'(ppi), 32'(v1));
         @(negedge clk);
      end
      hold_upd = 0; cap_en = 0; scan_en = 0; scan_in = 0;
      chk(seq_state == 3'd4, "R5 phase launch", 32'(seq_state), 4);
      chk(ppi == v1, "R6 ppi before launch", 32'(ppi), 32'(v1));
      @(negedge clk);
      chk(seq_state == 3'd5, "R5 phase capture", 32'(seq_state), 5);
      chk(ppi == v2, "R7 launch vector", 32'(ppi), 32'(v2));
      cap = logic_model(v2);
      @(negedge clk);
      chk(seq_state == 3'd6, "R8 capture after one cycle", 32'(seq_state), 6);
      for (int k = 0; k < N; k++) begin
         chk(scan_out == cap[N-1-k], "R9 unload bit", 32'(scan_out), 32'(cap[N-1-k]));
         @(negedge clk);
      end
      chk(seq_state == 3'd7 && done, "R10 done phase", {29'd0, seq_state} | (32'(done) << 8), 32'h107);
      @(negedge clk);
      chk(seq_state == 3'd0 && !done, "R10 back to idle", {29'd0, seq_state} | (32'(done) << 8), 0);
      m_q = '0; m_h = v2;
   endtask

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      chk(ppi == '0, "R1 ppi reset", 32'(ppi), 0);
      chk(scan_out == 1'b0, "R1 scan_out reset", 32'(scan_out), 0);
      chk(seq_state == 3'd0 && !done, "R1 seq reset", 32'(seq_state), 0);
      rst_n = 1;
      @(negedge clk);
      for (int k = 0; k < N; k++) manual_cycle(1, 0, 0, 1);
      chk(m_q == '1, "R1 R2 cells ones after fill", 32'(m_q), 32'hFF);
      manual_cycle(0, 1, 0, 0);
      chk(ppi == '1, "R3 directed copy", 32'(ppi), 32'hFF);
      manual_cycle(1, 0, 1, 0);
      manual_cycle(0, 0, 1, 0);
      for (int i = 0; i < 200; i++)
         manual_cycle(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      run_seq(8'h00, 8'hFF, 0);
      run_seq(8'hFF, 8'h00, 0);
      run_seq(8'h3C, 8'h96, 1);
      for (int i = 0; i < 4; i++) run_seq(8'($urandom), 8'($urandom), 1'($urandom));
      for (int i = 0; i < 40; i++)
         manual_cycle(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R5 actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule